// File: doc/BRIEF.md
# Word-Granular ECC Read-Modify-Write Unit

This block connects a byte-addressed requester to a storage array whose words are 38 bits wide. Each word carries 32 data bits, which are four byte lanes, and 6 check bits of a single-error-correcting Hamming code. A read fetches the word that holds the addressed byte, repairs any one flipped bit, and returns the byte on the selected lane.

A single-byte write cannot update part of a codeword. The unit first fetches the word and corrects it. It then replaces one lane, encodes all 32 bits again, and writes the whole codeword back. A write that supplies all four lanes of an aligned word is encoded directly and written in one memory cycle, with no fetch.

A ready/valid handshake on the request side keeps the unit busy until each operation, including any write-back, is finished. A one-cycle flag reports every bit the code repaired.

Top module: `ecc_rmw_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1, and `rsp_valid`, `corr_pulse` and `mem_en` are 0.
- R2: A read is accepted on a clock edge where `req_valid` and `req_ready` are both 1. On the next edge the unit issues one memory read (`mem_en`=1, `mem_we`=0) at word `req_addr[ADDR_W-1:2]`. `rsp_valid` is high for exactly one cycle, two edges after the accepting edge. In that cycle `rsp_rdata` holds data bits `[8k+7:8k]`, where k is `req_addr[1:0]`.
- R3: If exactly one of the 38 codeword bits is flipped, a data flip is repaired in the returned byte. `corr_pulse` is then high for exactly one cycle, in the cycle of the response or of the write-back. It stays 0 for a clean word.
- R4: If the syndrome points at a check-bit position (1, 2, 4, 8, 16 or 32), only that check bit is considered wrong. The returned data is unchanged and `corr_pulse` is still raised.
- R5: A byte write (`req_write`=1, `req_full`=0) first issues a memory read. Two edges after that read it issues one memory write of the whole codeword. The written data is the corrected word with lane `req_addr[1:0]` replaced by `req_wdata[7:0]`, and the other three lanes are kept.
- R6: After a write-back, the stored codeword is error-free, so a later read of any lane of that word gives `corr_pulse`=0.
- R7: A full-word write (`req_write`=1, `req_full`=1) issues no memory read. It issues a single memory write on the edge after acceptance, and `req_ready` returns one cycle later. `req_addr[1:0]` is ignored.
- R8: `req_ready` is 0 from the edge after acceptance until the edge after the last memory access of the operation. That point is the response for a read and the memory write for either kind of write.
- R9: Codeword layout: codeword bit p-1 holds Hamming position p, for p from 1 to 38. Check bit j sits at position 2^j and makes even parity over all positions that have bit j set. Data bits 0 to 31 fill the remaining positions in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | With req_write: write all four lanes of the word |
| req_addr | input | ADDR_W | Byte address; [1:0] selects the lane |
| req_wdata | input | 32 | Full-word data, or byte data in [7:0] |
| rsp_valid | output | 1 | Read byte valid, one cycle |
| rsp_rdata | output | 8 | Read byte |
| corr_pulse | output | 1 | A single-bit error was repaired |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write when mem_en is 1 |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 38 | Codeword to store |
| mem_rdata | input | 38 | Codeword read, valid one cycle after the read access |

## Verification
Repairing a bit and writing back can fall in the same cycle. A byte write to a word that carries a flipped bit in another lane raises the correction flag in the same cycle as the memory write. The bench provokes this by flipping a chosen bit inside its RAM model just before a byte write. It judges the result by comparing the written codeword with its own encoding of the merged, repaired word, and by checking the flag in that same cycle. A later read of the untouched lanes must then show no correction.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int LANES  = DATA_W / BYTE_W;
  localparam int LANE_AW = $clog2(LANES);
  localparam int CHK_W  = 6;
  localparam int CW_W   = DATA_W + CHK_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_DATA,
    ST_WB
  } rmw_state_e;

  // Spread data over non-power-of-two positions, then fill parity slots.
  function automatic logic [CW_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] cw;
    logic par;
    int k;
    cw = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p-1] = d[k];
        k++;
      end
    end
    for (int j = 0; j < CHK_W; j++) begin
      par = 1'b0;
      for (int p = 1; p <= CW_W; p++) begin
        if (((p >> j) & 1) == 1) par = par ^ cw[p-1];
      end
      cw[(1 << j) - 1] = par;
    end
    return cw;
  endfunction

  function automatic logic [CHK_W-1:0] ecc_syndrome(input logic [CW_W-1:0] cw);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int p = 1; p <= CW_W; p++) begin
      if (cw[p-1]) s = s ^ CHK_W'(p);
    end
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] ecc_extract(input logic [CW_W-1:0] cw);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k] = cw[p-1];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_rmw_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);
  always_comb cw_o = ecc_encode(data_i);
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_rmw_pkg::*;
(
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic              fixed_o
);
  logic [CHK_W-1:0] syn;
  logic [CW_W-1:0]  repaired;

  always_comb begin
    syn      = ecc_syndrome(cw_i);
    repaired = cw_i;
    fixed_o  = 1'b0;
    // Syndromes beyond the codeword length are not a single-bit pattern.
    if (syn != '0 && syn <= CHK_W'(CW_W)) begin
      repaired[syn - CHK_W'(1)] = ~cw_i[syn - CHK_W'(1)];
      fixed_o = 1'b1;
    end
    data_o = ecc_extract(repaired);
  end
endmodule

// File: rtl/ecc_lane_mux.sv
module ecc_lane_mux
  import ecc_rmw_pkg::*;
(
  input  logic [DATA_W-1:0]  word_i,
  input  logic [LANE_AW-1:0] lane_i,
  input  logic [BYTE_W-1:0]  byte_i,
  output logic [BYTE_W-1:0]  sel_o,
  output logic [DATA_W-1:0]  merged_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged_o[g*BYTE_W +: BYTE_W] =
      (lane_i == LANE_AW'(g)) ? byte_i : word_i[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    sel_o = '0;
    for (int g = 0; g < LANES; g++) begin
      if (lane_i == LANE_AW'(g)) sel_o = word_i[g*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int WORD_AW = ADDR_W - LANE_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_full,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BYTE_W-1:0]  req_byte,
  input  logic [CW_W-1:0]    full_cw,
  input  logic [CW_W-1:0]    merged_cw,
  input  logic [BYTE_W-1:0]  sel_byte,
  input  logic               dec_fixed,
  output logic [LANE_AW-1:0] lane_q,
  output logic [BYTE_W-1:0]  byte_q,
  output logic               rsp_valid,
  output logic [BYTE_W-1:0]  rsp_rdata,
  output logic               corr_pulse,
  output logic               mem_en,
  output logic               mem_we,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [CW_W-1:0]    mem_wdata
);
  rmw_state_e state;
  logic       wr_q;
  logic       accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wr_q       <= 1'b0;
      lane_q     <= '0;
      byte_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      corr_pulse <= 1'b0;
      mem_en     <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      corr_pulse <= 1'b0;
      mem_en     <= 1'b0;
      mem_we     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            mem_addr <= req_addr[ADDR_W-1:LANE_AW];
            lane_q   <= req_addr[LANE_AW-1:0];
            byte_q   <= req_byte;
            wr_q     <= req_write;
            mem_en   <= 1'b1;
            if (req_write && req_full) begin
              mem_we    <= 1'b1;
              mem_wdata <= full_cw;
              state     <= ST_WB;
            end else begin
              state <= ST_RD_WAIT;
            end
          end
        end
        ST_RD_WAIT: state <= ST_RD_DATA;
        ST_RD_DATA: begin
          corr_pulse <= dec_fixed;
          if (wr_q) begin
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_wdata <= merged_cw;
            state     <= ST_WB;
          end else begin
            rsp_valid <= 1'b1;
            rsp_rdata <= sel_byte;
            state     <= ST_IDLE;
          end
        end
        ST_WB:   state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);
  // R8
  write_frees_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |=> req_ready);
  // R7
  full_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write && req_full) |=> (mem_en && mem_we));
  // R5
  partial_reads_first_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !(req_write && req_full)) |=> (mem_en && !mem_we));
  // R2
  rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R3
  corr_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    corr_pulse |=> !corr_pulse);
  // R3
  corr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    corr_pulse |-> (rsp_valid || (mem_en && mem_we)));
endmodule

// File: rtl/ecc_rmw_unit.sv
module ecc_rmw_unit
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int WORD_AW = ADDR_W - LANE_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_full,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [BYTE_W-1:0]  rsp_rdata,
  output logic               corr_pulse,
  output logic               mem_en,
  output logic               mem_we,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [CW_W-1:0]    mem_wdata,
  input  logic [CW_W-1:0]    mem_rdata
);
  logic [DATA_W-1:0]  dec_data;
  logic               dec_fixed;
  logic [DATA_W-1:0]  merged;
  logic [BYTE_W-1:0]  sel_byte;
  logic [CW_W-1:0]    merged_cw;
  logic [CW_W-1:0]    full_cw;
  logic [LANE_AW-1:0] lane_q;
  logic [BYTE_W-1:0]  byte_q;

  ecc_decoder u_dec (
    .cw_i    (mem_rdata),
    .data_o  (dec_data),
    .fixed_o (dec_fixed)
  );

  ecc_lane_mux u_lane (
    .word_i   (dec_data),
    .lane_i   (lane_q),
    .byte_i   (byte_q),
    .sel_o    (sel_byte),
    .merged_o (merged)
  );

  ecc_encoder u_enc_merge (
    .data_i (merged),
    .cw_o   (merged_cw)
  );

  ecc_encoder u_enc_full (
    .data_i (req_wdata),
    .cw_o   (full_cw)
  );

  ecc_rmw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_full   (req_full),
    .req_addr   (req_addr),
    .req_byte   (req_wdata[BYTE_W-1:0]),
    .full_cw    (full_cw),
    .merged_cw  (merged_cw),
    .sel_byte   (sel_byte),
    .dec_fixed  (dec_fixed),
    .lane_q     (lane_q),
    .byte_q     (byte_q),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .corr_pulse (corr_pulse),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );
endmodule

// File: tb/ecc_rmw_unit_bench.sv
module ecc_rmw_unit_bench;
  localparam int ADDR_W = 10;
  localparam int WAW    = ADDR_W - 2;
  localparam int WORDS  = 1 << WAW;
  localparam int CWW    = 38;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst = 1'b1;
  logic              req_valid = 1'b0, req_write = 1'b0, req_full = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              req_ready, rsp_valid, corr_pulse, mem_en, mem_we;
  logic [7:0]        rsp_rdata;
  logic [WAW-1:0]    mem_addr;
  logic [CWW-1:0]    mem_wdata, mem_rdata;

  logic [CWW-1:0] ram [WORDS];
  logic           inj_en = 1'b0;
  logic [WAW-1:0] inj_addr = '0;
  logic [CWW-1:0] inj_mask = '0;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata     <= ram[mem_addr];
    end
    if (inj_en) ram[inj_addr] <= ram[inj_addr] ^ inj_mask;
  end

  ecc_rmw_unit #(.ADDR_W(ADDR_W)) u_ecc_rmw_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_full(req_full), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .corr_pulse(corr_pulse), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] model [WORDS];
  int          errpos [WORDS];

  // R9 layout, computed by walking positions and skipping powers of two
  function automatic logic [CWW-1:0] tb_encode(input logic [31:0] d);
    logic [CWW-1:0] cw;
    logic par;
    int pos;
    cw = '0;
    pos = 1;
    for (int i = 0; i < 32; i++) begin
      while ($countones(pos) == 1) pos++;
      cw[pos-1] = d[i];
      pos++;
    end
    for (int j = 0; j < 6; j++) begin
      par = 1'b0;
      for (int p = 1; p <= CWW; p++) if (((p >> j) & 1) == 1) par ^= cw[p-1];
      cw[(1 << j) - 1] = par;
    end
    return cw;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic inject(input int w, input int p);
    @(negedge clk);
    inj_en = 1'b1; inj_addr = WAW'(w); inj_mask = CWW'(1) << (p - 1);
    @(negedge clk);
    inj_en = 1'b0;
    errpos[w] = (errpos[w] == p) ? 0 : p;
  endtask

  task automatic full_wr(input int w, input logic [31:0] d, input logic [1:0] junk);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_full = 1'b1;
    req_addr = (ADDR_W'(w) << 2) | ADDR_W'(junk); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_en && mem_we, "R7", "single write, no read", {mem_en, mem_we}, 3);
    chk(mem_addr == WAW'(w), "R7", "word address", mem_addr, w);
    chk(mem_wdata == tb_encode(d), "R9", "full codeword", mem_wdata, tb_encode(d));
    chk(!req_ready, "R8", "busy during write", req_ready, 0);
    @(negedge clk);
    chk(req_ready, "R7", "ready one cycle later", req_ready, 1);
    model[w] = d; errpos[w] = 0;
  endtask

  task automatic rd(input int w, input int lane, input string tag);
    logic [7:0] exp;
    bit expc;
    exp = model[w][lane*8 +: 8];
    expc = (errpos[w] != 0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_full = 1'b0;
    req_addr = ADDR_W'(w * 4 + lane); req_wdata = $urandom;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_en && !mem_we, "R2", "read issued", {mem_en, mem_we}, 2);
    chk(!req_ready, "R8", "busy after accept", req_ready, 0);
    @(negedge clk);
    chk(!rsp_valid, "R2", "no early response", rsp_valid, 0);
    @(negedge clk);
    chk(rsp_valid, "R2", "response cycle", rsp_valid, 1);
    chk(rsp_rdata == exp, tag, "read byte", rsp_rdata, exp);
    chk(corr_pulse == expc, tag, "correction flag", corr_pulse, expc);
    chk(req_ready, "R8", "ready with response", req_ready, 1);
    @(negedge clk);
    chk(!rsp_valid && !corr_pulse, "R2", "pulses last one cycle",
        {rsp_valid, corr_pulse}, 0);
  endtask

  task automatic byte_wr(input int w, input int lane, input logic [7:0] b);
    logic [31:0] nd;
    bit expc;
    nd = model[w];
    nd[lane*8 +: 8] = b;
    expc = (errpos[w] != 0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_full = 1'b0;
    req_addr = ADDR_W'(w * 4 + lane); req_wdata = {$urandom, b};
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_en && !mem_we, "R5", "read before merge", {mem_en, mem_we}, 2);
    @(negedge clk);
    @(negedge clk);
    chk(mem_en && mem_we, "R5", "write-back issued", {mem_en, mem_we}, 3);
    chk(mem_wdata == tb_encode(nd), "R5", "merged codeword", mem_wdata, tb_encode(nd));
    chk(corr_pulse == expc, "R3", "flag with write-back", corr_pulse, expc);
    chk(!req_ready, "R8", "busy during write-back", req_ready, 0);
    @(negedge clk);
    chk(req_ready, "R8", "ready after write-back", req_ready, 1);
    model[w] = nd; errpos[w] = 0;
  endtask

  initial begin : main
    void'($urandom(32'd2718));
    repeat (2) @(negedge clk);
    chk(req_ready && !rsp_valid && !corr_pulse && !mem_en, "R1", "in reset",
        {req_ready, rsp_valid, corr_pulse, mem_en}, 8);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !corr_pulse && !mem_en, "R1", "after reset",
        {req_ready, rsp_valid, corr_pulse, mem_en}, 8);

    for (int w = 0; w < WORDS; w++) full_wr(w, $urandom, 2'($urandom));

    full_wr(5, 32'hA1B2C3D4, 2'd3);
    for (int l = 0; l < 4; l++) rd(5, l, "R2");
    full_wr(6, 32'h0, 2'd0);
    full_wr(7, 32'hFFFFFFFF, 2'd1);
    rd(6, 2, "R2");
    rd(7, 1, "R2");

    // R3: every data position; R4: every check position
    for (int p = 1; p <= CWW; p++) begin
      inject(9, p);
      rd(9, p % 4, ($countones(p) == 1) ? "R4" : "R3");
      inject(9, p);
    end

    // R5/R6: repair of another lane coincides with the write-back
    full_wr(11, 32'h12345678, 2'd0);
    inject(11, 3);
    byte_wr(11, 2, 8'hEE);
    rd(11, 0, "R6");
    rd(11, 1, "R6");
    rd(11, 2, "R6");
    inject(12, 16);
    byte_wr(12, 0, 8'h5A);
    rd(12, 3, "R6");

    for (int i = 0; i < 400; i++) begin
      int w, l, k;
      w = int'($urandom % WORDS);
      l = int'($urandom % 4);
      k = int'($urandom % 3);
      if (($urandom % 3) == 0 && errpos[w] == 0) inject(w, int'($urandom % CWW) + 1);
      if (k == 0)      rd(w, l, "R3");
      else if (k == 1) byte_wr(w, l, 8'($urandom));
      else             full_wr(w, $urandom, 2'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule